// File: doc/BRIEF.md
# Watch-Mode Power Controller

This block tracks the operating mode of a small microcontroller: full-speed active, reduced-speed active, subactive (low-speed clock) or watch. From any running mode, a one-cycle sleep strobe moves it into watch when two configuration bits both say so. In watch, the system clock stops and every peripheral clock is gated off. The exceptions are the timers and the event counter, which keep running, and the display controller, which follows its own run bit.

A qualified wake-up interrupt brings the block out of watch. The low-speed and medium-speed selects, sampled when the wake is taken, pick the mode it returns to. A return to subactive happens at once. A return to either active mode first holds the system clock off for an oscillator-settling interval. That interval is chosen by a 3-bit code and counted on the free-running reference clock. Each exit fires a one-cycle pulse that starts interrupt handling. An asserted reset leaves watch immediately and restores full-speed active.

Top module: `pwr_watch_ctrl`

## Requirements
- R1: When the mode is not watch and `sleep_req` is sampled high with both `stby_sel` and `tmr_mode3` at 1, the mode is watch (`mode_o` = 2'b11) after that edge. A sleep strobe with either bit at 0 leaves the mode unchanged. A sleep strobe while in watch has no effect.
- R2: While the mode is watch, `sysclk_en_o` is 0. Bits 0 to 3 of `clk_en_o` (timer A, timer F, timer G, event counter) are 1, bit 4 (display) equals `lcd_run`, and all higher bits are 0. In every other mode, `sysclk_en_o` and every bit of `clk_en_o` are 1.
- R3: The wake vector has this bit layout: bit 0 timer A, bit 1 timer F, bit 2 timer G, bit 3 IRQ0, bits 4 to 11 wake pins 0 to 7. Any single bit with its request and enable both set, and `irq_mask` at 0, qualifies as a wake.
- R4: The return mode depends on the selects sampled at the wake edge. `lowspd_on`=1 selects subactive (2'b10) whatever `medspd_on` is. `lowspd_on`=0 with `medspd_on`=0 selects full-speed active (2'b00). `lowspd_on`=0 with `medspd_on`=1 selects reduced-speed active (2'b01).
- R5: For a return to an active mode, `mode_o` stays 2'b11 and `sysclk_en_o` stays 0 for N further rising edges after the wake edge, where N is set by `settle_sel`. The codes map as follows: 0 gives 8192, 1 gives 16384, 2 gives 32768, 3 gives 65536, 4 gives 131072, 5 gives 2, 6 gives 8, and 7 gives 16. The mode changes on the N-th edge.
- R6: For a return to subactive, the mode changes on the wake edge itself, with no settling wait.
- R7: `exc_start_o` is high for exactly one cycle, and that cycle is the first one that shows the new mode after a watch exit. It is 0 at all other times.
- R8: A wake request is ignored, and the mode stays watch with no start pulse, when `irq_mask` is 1 or when that source's enable bit is 0.
- R9: While `rst_n` is low, the outputs are at once full-speed active, all clock enables 1, and `exc_start_o` 0. This holds in every mode, watch included. The release of `rst_n` is synchronised to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle sleep strobe |
| stby_sel | input | 1 | Standby-select configuration bit |
| tmr_mode3 | input | 1 | Timer-mode bit that admits watch |
| lowspd_on | input | 1 | Wake into subactive when 1 |
| medspd_on | input | 1 | Wake into reduced-speed active when 1 and lowspd_on is 0 |
| settle_sel | input | 3 | Oscillator-settling interval code |
| irq_mask | input | 1 | Global interrupt mask; 1 blocks all wakes |
| wake_req | input | N_WAKE | Wake-capable interrupt requests |
| wake_en | input | N_WAKE | Per-source interrupt enables |
| lcd_run | input | 1 | Display controller run bit, honoured in watch |
| mode_o | output | 2 | Current mode code |
| clk_en_o | output | N_PERIPH | Per-peripheral clock enables |
| sysclk_en_o | output | 1 | System clock enable |
| exc_start_o | output | 1 | One-cycle start of interrupt handling |

## Verification
The assertions watch four things on every cycle: the gating pattern in watch, the entry condition, the fact that a masked or disabled request never moves the block out of watch outside settling, and the shape of the start pulse. Only the bench scenarios can show the settling length counted edge by edge for each code, including the long 8192- and 16384-cycle codes. The same holds for the return-mode choice for every select combination, each of the twelve wake positions, and an asynchronous reset taken mid-watch.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    MODE_HS    = 2'b00,
    MODE_MS    = 2'b01,
    MODE_SUB   = 2'b10,
    MODE_WATCH = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_HS,
    ST_MS,
    ST_SUB,
    ST_WATCH,
    ST_SETTLE
  } pstate_e;

  // peripheral enable bit positions
  localparam int PE_TMR_A = 0;
  localparam int PE_TMR_F = 1;
  localparam int PE_TMR_G = 2;
  localparam int PE_EVCNT = 3;
  localparam int PE_LCD   = 4;

  // settling interval in reference clocks for a 3-bit code
  function automatic int unsigned settle_cycles(input logic [2:0] code);
    int unsigned n;
    case (code)
      3'd5:    n = 2;
      3'd6:    n = 8;
      3'd7:    n = 16;
      default: n = 32'd1 << (13 + int'(code));
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
  parameter int N_WAKE = 12
) (
  input  logic [N_WAKE-1:0] req,
  input  logic [N_WAKE-1:0] en,
  input  logic              mask,
  output logic              hit
);
  logic [N_WAKE-1:0] live;

  always_comb begin
    live = req & en;
    hit  = !mask && (|live);
  end
endmodule

// File: rtl/pwr_settle_cnt.sv
module pwr_settle_cnt #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = load || (run && (cnt_q != '0));
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
    done   = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate #(
  parameter int N_PERIPH = 8
) (
  input  logic                watch,
  input  logic                lcd_run,
  output logic [N_PERIPH-1:0] en
);
  import pwr_pkg::*;

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_en
    if (i <= PE_EVCNT) begin : g_keep
      assign en[i] = 1'b1;
    end else if (i == PE_LCD) begin : g_lcd
      assign en[i] = watch ? lcd_run : 1'b1;
    end else begin : g_gate
      assign en[i] = !watch;
    end
  end
endmodule

// File: rtl/pwr_watch_ctrl.sv
module pwr_watch_ctrl
  import pwr_pkg::*;
#(
  parameter int N_WAKE   = 12,
  parameter int N_PERIPH = 8,
  parameter int CNT_W    = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_req,
  input  logic                stby_sel,
  input  logic                tmr_mode3,
  input  logic                lowspd_on,
  input  logic                medspd_on,
  input  logic [2:0]          settle_sel,
  input  logic                irq_mask,
  input  logic [N_WAKE-1:0]   wake_req,
  input  logic [N_WAKE-1:0]   wake_en,
  input  logic                lcd_run,
  output logic [1:0]          mode_o,
  output logic [N_PERIPH-1:0] clk_en_o,
  output logic                sysclk_en_o,
  output logic                exc_start_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  pstate_e          st_q, st_d;
  mode_e            tgt_q, tgt_d;
  logic             exc_q, exc_d;
  logic             wake_hit, settle_done, settle_load, settling, in_watch;
  logic             tgt_ce;
  logic [CNT_W-1:0] settle_val;

  pwr_wake_qual #(.N_WAKE(N_WAKE)) u_qual (
    .req  (wake_req),
    .en   (wake_en),
    .mask (irq_mask),
    .hit  (wake_hit)
  );

  assign settle_val = CNT_W'(settle_cycles(settle_sel) - 32'd1);

  pwr_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (settle_load),
    .load_val (settle_val),
    .run      (settling),
    .done     (settle_done)
  );

  // next state
  always_comb begin
    st_d        = st_q;
    tgt_d       = tgt_q;
    tgt_ce      = 1'b0;
    exc_d       = 1'b0;
    settle_load = 1'b0;
    case (st_q)
      ST_HS, ST_MS, ST_SUB: begin
        if (sleep_req && stby_sel && tmr_mode3) st_d = ST_WATCH;
      end
      ST_WATCH: begin
        if (wake_hit) begin
          if (lowspd_on) begin
            st_d  = ST_SUB;
            exc_d = 1'b1;
          end else begin
            st_d        = ST_SETTLE;
            settle_load = 1'b1;
            tgt_ce      = 1'b1;
            tgt_d       = medspd_on ? MODE_MS : MODE_HS;
          end
        end
      end
      ST_SETTLE: begin
        if (settle_done) begin
          st_d  = (tgt_q == MODE_MS) ? ST_MS : ST_HS;
          exc_d = 1'b1;
        end
      end
      default: st_d = ST_HS;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q  <= ST_HS;
      exc_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      exc_q <= exc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    tgt_q <= MODE_HS;
    else if (tgt_ce) tgt_q <= tgt_d;
  end

  // outputs
  assign settling = (st_q == ST_SETTLE);
  assign in_watch = (st_q == ST_WATCH) || settling;

  always_comb begin
    case (st_q)
      ST_MS:   mode_o = MODE_MS;
      ST_SUB:  mode_o = MODE_SUB;
      ST_HS:   mode_o = MODE_HS;
      default: mode_o = MODE_WATCH;
    endcase
  end

  assign sysclk_en_o = !in_watch;
  assign exc_start_o = exc_q;

  pwr_clk_gate #(.N_PERIPH(N_PERIPH)) u_gate (
    .watch   (in_watch),
    .lcd_run (lcd_run),
    .en      (clk_en_o)
  );
endmodule

// File: rtl/pwr_watch_ctrl_chk.sv
module pwr_watch_ctrl_chk #(
  parameter int N_WAKE   = 12,
  parameter int N_PERIPH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sleep_req,
  input logic                stby_sel,
  input logic                tmr_mode3,
  input logic                lowspd_on,
  input logic                irq_mask,
  input logic [N_WAKE-1:0]   wake_req,
  input logic [N_WAKE-1:0]   wake_en,
  input logic                lcd_run,
  input logic                settling,
  input logic [1:0]          mode_o,
  input logic [N_PERIPH-1:0] clk_en_o,
  input logic                sysclk_en_o,
  input logic                exc_start_o
);
  AST_ENTER_WATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b11 && sleep_req && stby_sel && tmr_mode3) |=> (mode_o == 2'b11)); // R1

  AST_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b11 && !(sleep_req && stby_sel && tmr_mode3)) |=> (mode_o == $past(mode_o))); // R1

  AST_WATCH_GATING: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11) |-> (!sysclk_en_o && clk_en_o[3:0] == 4'hF && clk_en_o[4] == lcd_run
                           && (clk_en_o >> 5) == '0)); // R2

  AST_RUN_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b11) |-> (sysclk_en_o && (&clk_en_o))); // R2

  AST_BLOCKED_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11 && !settling && (irq_mask || !(|(wake_req & wake_en)))) |=> (mode_o == 2'b11)); // R8

  AST_SUB_CHOICE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_start_o && mode_o == 2'b10) |-> $past(lowspd_on)); // R4

  AST_PULSE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start_o |-> ($past(mode_o) == 2'b11 && mode_o != 2'b11)); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start_o |=> !exc_start_o); // R7

  AST_EXIT_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11) |=> (mode_o == 2'b11 || exc_start_o)); // R7
endmodule

bind pwr_watch_ctrl pwr_watch_ctrl_chk #(.N_WAKE(N_WAKE), .N_PERIPH(N_PERIPH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .sleep_req   (sleep_req),
  .stby_sel    (stby_sel),
  .tmr_mode3   (tmr_mode3),
  .lowspd_on   (lowspd_on),
  .irq_mask    (irq_mask),
  .wake_req    (wake_req),
  .wake_en     (wake_en),
  .lcd_run     (lcd_run),
  .settling    (settling),
  .mode_o      (mode_o),
  .clk_en_o    (clk_en_o),
  .sysclk_en_o (sysclk_en_o),
  .exc_start_o (exc_start_o)
);

// File: tb/pwr_watch_ctrl_tb.sv
module pwr_watch_ctrl_tb;
  localparam int NW = 12;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sleep_req, stby_sel, tmr_mode3, lowspd_on, medspd_on, irq_mask, lcd_run;
  logic [2:0]    settle_sel;
  logic [NW-1:0] wake_req, wake_en;
  logic [1:0]    mode_o;
  logic [NP-1:0] clk_en_o;
  logic          sysclk_en_o, exc_start_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwr_watch_ctrl #(.N_WAKE(NW), .N_PERIPH(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_sel(stby_sel),
    .tmr_mode3(tmr_mode3), .lowspd_on(lowspd_on), .medspd_on(medspd_on),
    .settle_sel(settle_sel), .irq_mask(irq_mask), .wake_req(wake_req),
    .wake_en(wake_en), .lcd_run(lcd_run), .mode_o(mode_o), .clk_en_o(clk_en_o),
    .sysclk_en_o(sysclk_en_o), .exc_start_o(exc_start_o)
  );

  function automatic int exp_settle(input logic [2:0] c);
    case (c)
      3'd0: return 8192;   3'd1: return 16384;  3'd2: return 32768;
      3'd3: return 65536;  3'd4: return 131072; 3'd5: return 2;
      3'd6: return 8;      default: return 16;
    endcase
  endfunction

  function automatic logic [1:0] exp_target(input logic lo, input logic med);
    if (lo) return 2'b10;
    return med ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [NP-1:0] exp_en(input logic watch, input logic lcd);
    logic [NP-1:0] v;
    v = '1;
    if (watch) begin
      v = '0;
      v[3:0] = 4'hF;
      v[4] = lcd;
    end
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic enter_watch();
    stby_sel = 1; tmr_mode3 = 1; sleep_req = 1;
    tick();
    sleep_req = 0;
    chk("R1 enter watch", 32'(mode_o), 32'd3);
    chk("R2 watch enables", 32'(clk_en_o), 32'(exp_en(1'b1, lcd_run)));
    chk("R2 sysclk off", 32'(sysclk_en_o), 32'd0);
  endtask

  // wake from watch through source idx; expects a qualified wake
  task automatic wake(input int idx, input logic lo, input logic med, input logic [2:0] sel);
    int n;
    lowspd_on = lo; medspd_on = med; settle_sel = sel; irq_mask = 0;
    wake_req = '0; wake_en = '0;
    wake_req[idx] = 1'b1; wake_en[idx] = 1'b1;
    tick();
    wake_req = '0;
    lowspd_on = ~lo; medspd_on = ~med;   // later changes must not matter
    if (lo) begin
      chk("R6 subactive at once", 32'(mode_o), 32'd2);
      chk("R7 pulse sub", 32'(exc_start_o), 32'd1);
    end else begin
      n = exp_settle(sel);
      for (int i = 1; i < n; i++) begin
        @(posedge clk);
        if (i == n - 1 || i == 1) begin
          @(negedge clk);
          chk("R5 still watch in settle", 32'(mode_o), 32'd3);
          chk("R5 sysclk held off", 32'(sysclk_en_o), 32'd0);
        end else @(negedge clk);
      end
      tick();
      chk("R4 R5 target mode", 32'(mode_o), 32'(exp_target(lo, med)));
      chk("R7 pulse active", 32'(exc_start_o), 32'd1);
    end
    chk("R2 run enables", 32'(clk_en_o), 32'(exp_en(1'b0, lcd_run)));
    tick();
    chk("R7 pulse one cycle", 32'(exc_start_o), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    rst_n = 0; sleep_req = 0; stby_sel = 0; tmr_mode3 = 0; lowspd_on = 0;
    medspd_on = 0; irq_mask = 0; lcd_run = 0; settle_sel = 3'd5;
    wake_req = '0; wake_en = '0;
    @(negedge clk);
    chk("R9 reset mode", 32'(mode_o), 32'd0);
    chk("R9 reset enables", 32'(clk_en_o), 32'(exp_en(1'b0, 1'b0)));
    chk("R9 reset pulse", 32'(exc_start_o), 32'd0);
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();

    // R1: sleep with a qualifier bit low does nothing
    stby_sel = 0; tmr_mode3 = 1; sleep_req = 1; tick();
    chk("R1 no entry stby=0", 32'(mode_o), 32'd0);
    stby_sel = 1; tmr_mode3 = 0; tick();
    chk("R1 no entry tmr=0", 32'(mode_o), 32'd0);
    sleep_req = 0;

    // R3: wake while running has no effect
    wake_req = '1; wake_en = '1; tick(); tick();
    chk("R3 no effect when running", 32'(mode_o), 32'd0);
    chk("R7 no pulse when running", 32'(exc_start_o), 32'd0);
    wake_req = '0;

    // directed: long settling codes, all target combinations
    enter_watch();
    wake(0, 1'b0, 1'b0, 3'd0);
    enter_watch();
    wake(3, 1'b0, 1'b1, 3'd1);
    enter_watch();
    wake(11, 1'b1, 1'b1, 3'd0);

    // R1: entry from subactive, and sleep in watch ignored
    lcd_run = 1;
    enter_watch();
    sleep_req = 1; tick(); sleep_req = 0;
    chk("R1 sleep ignored in watch", 32'(mode_o), 32'd3);
    chk("R2 lcd follows run bit", 32'(clk_en_o[4]), 32'd1);

    // R9: reset during watch
    rst_n = 0; #1;
    chk("R9 async exit mode", 32'(mode_o), 32'd0);
    chk("R9 async exit enables", 32'(clk_en_o), 32'(exp_en(1'b0, 1'b0)));
    @(negedge clk); rst_n = 1;
    repeat (4) tick();
    chk("R9 stays active after release", 32'(mode_o), 32'd0);

    // R3: each wake position
    for (int s = 0; s < NW; s++) begin
      enter_watch();
      wake(s, 1'b0, 1'(s % 2), 3'd5);
    end

    // random mix with blocked wakes (R8)
    for (int it = 0; it < 40; it++) begin
      int src;
      lcd_run = 1'($urandom_range(0, 1));
      enter_watch();
      src = $urandom_range(0, NW - 1);
      if ($urandom_range(0, 2) == 0) begin
        irq_mask = 1'($urandom_range(0, 1));
        wake_req = '0; wake_en = '1;
        wake_req[src] = 1'b1;
        if (!irq_mask) wake_en[src] = 1'b0;
        lowspd_on = 1'($urandom_range(0, 1));
        repeat (3) tick();
        chk("R8 blocked wake stays", 32'(mode_o), 32'd3);
        chk("R8 blocked wake no pulse", 32'(exc_start_o), 32'd0);
        wake_req = '0; irq_mask = 0;
      end
      wake(src, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           3'($urandom_range(5, 7)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule